// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block converts addresses from a local bus into PCI bus addresses through three programmable windows. Each window holds a base setting and a map setting. The base setting gives the local start address, a power-of-two size, a prefetch flag and an enable bit. The map setting gives the PCI start address, the cycle type and the rule for the two lowest address lines. On every local access the block compares the address against all windows at once and uses the lowest-numbered enabled window that matches. One cycle later it presents the translated address, the cycle type and the prefetch flag. When no window matches it raises a miss instead.

Windows may overlap, and the lower index always wins. Software uses this to enlarge window 0 until it covers window 1 completely. Window 1 can then be reprogrammed for configuration cycles without disturbing ordinary memory traffic. Afterwards window 1 is restored and window 0 is shrunk back, which uncovers window 1 again. Software writes the registers through a single-cycle write port.

Top module: `pwt_translator`

## Requirements
- R1: Reset clears every window register, including all enable bits. Until software programs a window, every access returns a miss.
- R2: An access presented with `acc_valid` high in one cycle produces `out_valid` high in the next cycle. `out_valid` is low in a cycle that follows a cycle with no access.
- R3: A window matches when its enable bit is set and local address bits 31 down to 20+S equal the same bits of its base address, where S is its size code.
- R4: A size code S from 0 to 11 selects a window of 1 MB shifted left by S (1 MB up to 2 GB). A window with a size code from 12 to 15 never matches.
- R5: When several enabled windows match, the one with the lowest index provides the result, and `out_win` reports that index.
- R6: On a hit, `out_addr` takes bits 31 down to 20+S from the map address and all lower bits from the local address.
- R7: Map bit 0 controls `out_addr[1:0]`. When the bit is 0 these lines are forced to 00. When it is 1 they are copied from the local address.
- R8: On a hit, `out_type` equals map bits 3:1 and `out_prefetch` equals base bit 1. The type codes are 001 for I/O, 011 for memory, 101 for configuration and 110 for messaging. On a miss, `out_hit`, `out_type`, `out_prefetch`, `out_win` and `out_addr` are all 0.
- R9: Windows 0 and 1 store any type code. Window 2 stores only 001 or 110. Any other code written to window 2 is stored as 001.
- R10: Register layout:
  - `wr_sel` = {window index, map select}. Map select 0 addresses the base register and 1 addresses the map register.
  - Base register: bits 31:20 base address, bits 7:4 size code, bit 1 prefetch, bit 0 enable.
  - Map register: bits 31:20 map address, bits 3:1 type, bit 0 low-line control.
  - All other data bits are ignored.
  - Writes that select window index 3 are ignored.
- R11: An access presented in the same cycle as a register write uses the register values from before that write. An access in any later cycle uses the new values.
- R12: Enlarging window 0 from size code 8 (256 MB) to 9 (512 MB) fully hides window 1 for addresses inside the larger window. Shrinking it back makes window 1 visible again, with window 0's map register left unchanged throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: {window index, map select} |
| wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | Local access present |
| acc_addr | input | 32 | Local bus address |
| out_valid | output | 1 | Translation result valid (one cycle after the access) |
| out_hit | output | 1 | A window matched (low means miss) |
| out_win | output | 2 | Index of the selected window |
| out_addr | output | 32 | Translated PCI address |
| out_type | output | 3 | PCI cycle type code, 000 on a miss |
| out_prefetch | output | 1 | Prefetch flag of the selected window |

## Verification
The properties assume that `acc_addr` is stable and defined in every cycle in which `acc_valid` is high. They also assume that the translated low address lines are compared one cycle later against the address sampled with the access. The bench drives inputs only on falling edges and holds each access for exactly one cycle, so both assumptions hold. The bench also stores only type codes from the defined set, which keeps the last-window property meaningful. Overlap cases are built so that each address falls in a known set of windows, making the expected winner obvious from the requirements.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
    localparam int ADDR_W        = 32;
    localparam int PAGE_LSB      = 20;
    localparam int PAGE_W        = ADDR_W - PAGE_LSB;
    localparam int SIZE_W        = 4;
    localparam int MAX_SIZE_CODE = 11;
    localparam int TYPE_W        = 3;

    // register field positions
    localparam int SZ_LSB  = 4;
    localparam int PF_BIT  = 1;
    localparam int EN_BIT  = 0;
    localparam int TY_LSB  = 1;
    localparam int ADL_BIT = 0;

    localparam logic [TYPE_W-1:0] CYC_NONE = 3'b000;
    localparam logic [TYPE_W-1:0] CYC_IO   = 3'b001;
    localparam logic [TYPE_W-1:0] CYC_MEM  = 3'b011;
    localparam logic [TYPE_W-1:0] CYC_CFG  = 3'b101;
    localparam logic [TYPE_W-1:0] CYC_MSG  = 3'b110;

    typedef struct packed {
        logic [PAGE_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic              pref;
        logic              en;
    } base_t;

    typedef struct packed {
        logic [PAGE_W-1:0] addr;
        logic [TYPE_W-1:0] ctype;
        logic              adlow;
    } map_t;
endpackage

// File: rtl/pwt_regfile.sv
module pwt_regfile
    import pwt_pkg::*;
#(
    parameter  int NUM_WIN = 3,
    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [WIN_W:0]            wr_sel,
    input  logic [ADDR_W-1:0]         wr_data,
    output base_t [NUM_WIN-1:0]       bases_o,
    output map_t  [NUM_WIN-1:0]       maps_o
);
    localparam int IO_ONLY_WIN = NUM_WIN - 1;

    typedef struct packed {
        base_t [NUM_WIN-1:0] base;
        map_t  [NUM_WIN-1:0] map;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  [TYPE_W-1:0] wr_type;
    logic  unused_bits;

    assign wr_type     = wr_data[TY_LSB +: TYPE_W];
    assign unused_bits = ^wr_data[PAGE_LSB-1:8];

    always_comb begin
        regs_d = regs_q;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (wr_en && (wr_sel[WIN_W:1] == WIN_W'(w))) begin
                if (wr_sel[0]) begin
                    regs_d.map[w].addr  = wr_data[ADDR_W-1:PAGE_LSB];
                    regs_d.map[w].adlow = wr_data[ADL_BIT];
                    if ((w == IO_ONLY_WIN) && (wr_type != CYC_IO) && (wr_type != CYC_MSG))
                        regs_d.map[w].ctype = CYC_IO;
                    else
                        regs_d.map[w].ctype = wr_type;
                end else begin
                    regs_d.base[w].addr = wr_data[ADDR_W-1:PAGE_LSB];
                    regs_d.base[w].size = wr_data[SZ_LSB +: SIZE_W];
                    regs_d.base[w].pref = wr_data[PF_BIT];
                    regs_d.base[w].en   = wr_data[EN_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bases_o = regs_q.base;
    assign maps_o  = regs_q.map;
endmodule

// File: rtl/pwt_window_match.sv
module pwt_window_match
    import pwt_pkg::*;
(
    input  logic [PAGE_W-1:0] base_addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              en,
    input  logic [PAGE_W-1:0] map_addr,
    input  logic              adlow,
    input  logic [ADDR_W-1:0] laddr,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);
    logic [PAGE_W-1:0] keep;   // page bits compared/substituted
    logic [PAGE_W-1:0] lpage;
    logic              legal;

    assign lpage = laddr[ADDR_W-1:PAGE_LSB];
    assign legal = (int'(size) <= MAX_SIZE_CODE);
    assign keep  = {PAGE_W{1'b1}} << size;
    assign hit   = en && legal && (((lpage ^ base_addr) & keep) == '0);
    assign xaddr = {(map_addr & keep) | (lpage & ~keep),
                    laddr[PAGE_LSB-1:2],
                    adlow ? laddr[1:0] : 2'b00};
endmodule

// File: rtl/pwt_priority.sv
module pwt_priority #(
    parameter  int NUM_WIN = 3,
    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] hit_i,
    output logic [NUM_WIN-1:0] grant_o,
    output logic [WIN_W-1:0]   idx_o,
    output logic               any_o
);
    logic seen;

    always_comb begin
        seen    = 1'b0;
        grant_o = '0;
        idx_o   = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit_i[i] && !seen) begin
                grant_o[i] = 1'b1;
                idx_o      = WIN_W'(i);
                seen       = 1'b1;
            end
        end
        any_o = seen;
    end
endmodule

// File: rtl/pwt_translator.sv
module pwt_translator
    import pwt_pkg::*;
#(
    parameter  int NUM_WIN = 3,
    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIN_W:0]    wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [WIN_W-1:0]  out_win,
    output logic [ADDR_W-1:0] out_addr,
    output logic [TYPE_W-1:0] out_type,
    output logic              out_prefetch
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [WIN_W-1:0]  win;
        logic [ADDR_W-1:0] addr;
        logic [TYPE_W-1:0] ctype;
        logic              pref;
    } res_t;

    base_t [NUM_WIN-1:0] bases;
    map_t  [NUM_WIN-1:0] maps;
    logic  [NUM_WIN-1:0] hits;
    logic  [NUM_WIN-1:0] grant;
    logic  [ADDR_W-1:0]  xaddr [NUM_WIN];
    logic  [WIN_W-1:0]   sel_idx;
    logic                any_hit;
    res_t                res_d, res_q;

    pwt_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .bases_o (bases),
        .maps_o  (maps)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        pwt_window_match u_match (
            .base_addr (bases[g].addr),
            .size      (bases[g].size),
            .en        (bases[g].en),
            .map_addr  (maps[g].addr),
            .adlow     (maps[g].adlow),
            .laddr     (acc_addr),
            .hit       (hits[g]),
            .xaddr     (xaddr[g])
        );
    end

    pwt_priority #(.NUM_WIN(NUM_WIN)) u_prio (
        .hit_i   (hits),
        .grant_o (grant),
        .idx_o   (sel_idx),
        .any_o   (any_hit)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = acc_valid;
        if (acc_valid && any_hit) begin
            res_d.hit = 1'b1;
            res_d.win = sel_idx;
            for (int w = 0; w < NUM_WIN; w++) begin
                if (grant[w]) begin
                    res_d.addr  = xaddr[w];
                    res_d.ctype = maps[w].ctype;
                    res_d.pref  = bases[w].pref;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid    = res_q.valid;
    assign out_hit      = res_q.hit;
    assign out_win      = res_q.win;
    assign out_addr     = res_q.addr;
    assign out_type     = res_q.ctype;
    assign out_prefetch = res_q.pref;
endmodule

// File: rtl/pwt_checks.sv
module pwt_checks #(
    parameter  int NUM_WIN = 3,
    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [19:0]      acc_low,
    input logic             out_valid,
    input logic             out_hit,
    input logic [WIN_W-1:0] out_win,
    input logic [31:0]      out_addr,
    input logic [2:0]       out_type,
    input logic             out_prefetch
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> out_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !out_valid);

    p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_type == 3'b000 && !out_prefetch
                                     && out_addr == '0 && out_win == '0));

    p_hit_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_valid && int'(out_win) < NUM_WIN));

    p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |-> out_addr[19:2] == $past(acc_low[19:2]));

    p_ad_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |->
            (out_addr[1:0] == 2'b00 || out_addr[1:0] == $past(acc_low[1:0])));

    p_last_win_type_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit && int'(out_win) == NUM_WIN - 1) |->
            (out_type == 3'b001 || out_type == 3'b110));
endmodule

bind pwt_translator pwt_checks #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_low      (acc_addr[19:0]),
    .out_valid    (out_valid),
    .out_hit      (out_hit),
    .out_win      (out_win),
    .out_addr     (out_addr),
    .out_type     (out_type),
    .out_prefetch (out_prefetch)
);

// File: tb/sim_pwt_translator.sv
module sim_pwt_translator;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [2:0] T_NONE = 3'b000;
    localparam logic [2:0] T_IO   = 3'b001;
    localparam logic [2:0] T_MEM  = 3'b011;
    localparam logic [2:0] T_CFG  = 3'b101;
    localparam logic [2:0] T_MSG  = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        out_valid, out_hit, out_prefetch;
    logic [1:0]  out_win;
    logic [31:0] out_addr;
    logic [2:0]  out_type;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwt_translator u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_win(out_win),
        .out_addr(out_addr), .out_type(out_type), .out_prefetch(out_prefetch)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        hit;
        logic [1:0]  win;
        logic [31:0] x;
        logic [2:0]  t;
        logic        p;
    } vec_t;

    // R3 R6 R7 R8: address table with the standard three-window setup
    localparam vec_t VECS [6] = '{
        '{32'h4123_4567, 1'b1, 2'd0, 32'h8123_4567, T_MEM,  1'b0},
        '{32'h5ABC_DEF3, 1'b1, 2'd1, 32'h1ABC_DEF0, T_MEM,  1'b1},
        '{32'h60FF_FFFF, 1'b1, 2'd2, 32'h00FF_FFFF, T_IO,   1'b0},
        '{32'h6100_0000, 1'b0, 2'd0, 32'h0000_0000, T_NONE, 1'b0},
        '{32'h3FFF_FFFC, 1'b0, 2'd0, 32'h0000_0000, T_NONE, 1'b0},
        '{32'h4FFF_FFFE, 1'b1, 2'd0, 32'h8FFF_FFFE, T_MEM,  1'b0}
    };

    function automatic logic [31:0] bw(logic [11:0] a, logic [3:0] sz, logic pf, logic en);
        return {a, 12'h000, sz, 2'b00, pf, en};
    endfunction

    function automatic logic [31:0] mw(logic [11:0] a, logic [2:0] t, logic adl);
        return {a, 16'h0000, t, adl};
    endfunction

    task automatic reg_write(input logic [1:0] win, input logic is_map, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = {win, is_map}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic compare(input string tag, input logic eh, input logic [1:0] ew,
                           input logic [31:0] ex, input logic [2:0] et, input logic ep);
        logic [39:0] got, exp;
        got = {out_valid, out_hit, out_win, out_addr, out_type, out_prefetch};
        exp = {1'b1, eh, ew, ex, et, ep};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got v%b h%b w%0d a%h t%b p%b expected v1 h%b w%0d a%h t%b p%b",
                     tag, out_valid, out_hit, out_win, out_addr, out_type, out_prefetch,
                     eh, ew, ex, et, ep);
        end
    endtask

    task automatic access_check(input string tag, input logic [31:0] a, input logic eh,
                                input logic [1:0] ew, input logic [31:0] ex,
                                input logic [2:0] et, input logic ep);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        compare(tag, eh, ew, ex, et, ep);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: out_valid=%b expected 0", tag, out_valid);
        end
    endtask

    task automatic std_setup();
        reg_write(2'd0, 1'b0, bw(12'h400, 4'd8, 1'b0, 1'b1));
        reg_write(2'd0, 1'b1, mw(12'h800, T_MEM, 1'b1));
        reg_write(2'd1, 1'b0, bw(12'h500, 4'd8, 1'b1, 1'b1));
        reg_write(2'd1, 1'b1, mw(12'h100, T_MEM, 1'b0));
        reg_write(2'd2, 1'b0, bw(12'h600, 4'd4, 1'b0, 1'b1));
        reg_write(2'd2, 1'b1, mw(12'h000, T_IO, 1'b1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_hit !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: v%b h%b expected v0 h0", out_valid, out_hit);
        end
        rst_n = 1'b1;
        access_check("R1 no window after reset", 32'h4000_0000, 1'b0, 2'd0, 32'h0, T_NONE, 1'b0);

        std_setup();
        for (int i = 0; i < 6; i++)
            access_check("R3/R6/R7/R8 table", VECS[i].a, VECS[i].hit, VECS[i].win,
                         VECS[i].x, VECS[i].t, VECS[i].p);
        idle_check("R2 idle after access");

        // R12: enlarge window 0, reuse window 1 for configuration, then restore
        reg_write(2'd0, 1'b0, bw(12'h400, 4'd9, 1'b0, 1'b1));
        access_check("R12 window 1 hidden", 32'h5ABC_DEF3, 1'b1, 2'd0, 32'h9ABC_DEF3, T_MEM, 1'b0);
        reg_write(2'd1, 1'b0, bw(12'h610, 4'd4, 1'b0, 1'b1));
        reg_write(2'd1, 1'b1, mw(12'h000, T_CFG, 1'b0));
        access_check("R12 config via window 1", 32'h6100_0803, 1'b1, 2'd1, 32'h0000_0800, T_CFG, 1'b0);
        reg_write(2'd1, 1'b0, bw(12'h500, 4'd8, 1'b1, 1'b1));
        reg_write(2'd1, 1'b1, mw(12'h100, T_MEM, 1'b0));
        access_check("R12 still hidden", 32'h5ABC_DEF3, 1'b1, 2'd0, 32'h9ABC_DEF3, T_MEM, 1'b0);
        reg_write(2'd0, 1'b0, bw(12'h400, 4'd8, 1'b0, 1'b1));
        access_check("R12 window 1 revealed", 32'h5ABC_DEF3, 1'b1, 2'd1, 32'h1ABC_DEF0, T_MEM, 1'b1);

        // R10: nonexistent window index and ignored data bits
        reg_write(2'd3, 1'b0, bw(12'h000, 4'd11, 1'b0, 1'b1));
        reg_write(2'd3, 1'b1, mw(12'hFFF, T_MEM, 1'b1));
        access_check("R10 index 3 ignored", 32'h3FFF_FFFC, 1'b0, 2'd0, 32'h0, T_NONE, 1'b0);
        reg_write(2'd0, 1'b0, {12'h400, 12'hFFF, 4'd8, 2'b11, 1'b0, 1'b1});
        reg_write(2'd0, 1'b1, {12'h800, 16'hFFFF, T_MEM, 1'b1});
        access_check("R10 spare bits ignored", 32'h4123_4567, 1'b1, 2'd0, 32'h8123_4567, T_MEM, 1'b0);

        // R11: access in the same cycle as a write sees the old registers
        @(negedge clk);
        wr_en = 1'b1; wr_sel = {2'd0, 1'b0}; wr_data = bw(12'h400, 4'd8, 1'b0, 1'b0);
        acc_valid = 1'b1; acc_addr = 32'h4123_4567;
        @(negedge clk);
        wr_en = 1'b0; acc_valid = 1'b0;
        compare("R11 same-cycle write uses old", 1'b1, 2'd0, 32'h8123_4567, T_MEM, 1'b0);
        access_check("R11 next access uses new", 32'h4123_4567, 1'b0, 2'd0, 32'h0, T_NONE, 1'b0);
        reg_write(2'd0, 1'b0, bw(12'h400, 4'd8, 1'b0, 1'b1));

        // R4: illegal size, largest and smallest size
        reg_write(2'd2, 1'b0, bw(12'h600, 4'd12, 1'b0, 1'b1));
        access_check("R4 size code 12 never matches", 32'h6000_0000, 1'b0, 2'd0, 32'h0, T_NONE, 1'b0);
        reg_write(2'd2, 1'b0, bw(12'h000, 4'd11, 1'b0, 1'b1));
        access_check("R4 2GB window", 32'h3FFF_FFFC, 1'b1, 2'd2, 32'h3FFF_FFFC, T_IO, 1'b0);
        access_check("R5 lower index wins overlap", 32'h4123_4567, 1'b1, 2'd0, 32'h8123_4567, T_MEM, 1'b0);
        reg_write(2'd2, 1'b0, bw(12'h7FF, 4'd0, 1'b0, 1'b1));
        reg_write(2'd2, 1'b1, mw(12'hABC, T_IO, 1'b1));
        access_check("R4 1MB window hit", 32'h7FF1_2345, 1'b1, 2'd2, 32'hABC1_2345, T_IO, 1'b0);
        access_check("R4 1MB window miss", 32'h7FE0_0000, 1'b0, 2'd0, 32'h0, T_NONE, 1'b0);

        // R9: last window type restriction
        reg_write(2'd2, 1'b0, bw(12'h000, 4'd11, 1'b0, 1'b1));
        reg_write(2'd2, 1'b1, mw(12'h000, T_CFG, 1'b1));
        access_check("R9 config on window 2 becomes IO", 32'h3000_0000, 1'b1, 2'd2, 32'h3000_0000, T_IO, 1'b0);
        reg_write(2'd2, 1'b1, mw(12'h000, T_MSG, 1'b1));
        access_check("R9 messaging kept on window 2", 32'h3000_0001, 1'b1, 2'd2, 32'h3000_0001, T_MSG, 1'b0);
        idle_check("R2 idle at end");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete in %0d cycles", WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule